// File: doc/BRIEF.md
# Wire-Under-Test Capture and Scan Localizer

This block models the capture side of an interconnect test. Several chains of wires under test run side by side. Each wire ends in an identity logic stage feeding a capture flip-flop. On each test vector the block drives a pattern onto every wire source. One clock later it captures the far end of each wire. It then works out which wire, if any, delivered a wrong value. An open defect is injected per wire through a fault mask. A masked wire forces a constant 0 into its capture flip-flop, whatever value its source drives.

Two observation modes are offered. In scan mode each chain shifts its captures out serially on its own primary output. The flip-flop nearest the output comes out first. The block compares each shifted bit against the vector value expected for that position, and turns the shift count of the first mismatch into a wire index. In readback mode all captures are compared at once after each vector. This reaches the same verdict in far fewer cycles. A run stops at the first fault found. If every vector passes on every chain, the run ends with a no-fault result.

Top module: `wut_scan_localizer`

## Requirements
- R1: While reset is held and after its release, busy, done, fault_found, fault_chain, fault_wire, fault_vec and every scan_out bit are 0.
- R2: A run applies four vectors in a fixed order, identical on every chain. Vector index 0 drives every wire to 0. Index 1 drives wire w to bit 0 of w, so odd wires are 1. Index 2 drives wire w to the inverse of bit 0 of w, so even wires are 1. Index 3 drives every wire to 1.
- R3: A source value is captured in its wire's flip-flop on the clock after it is launched, unchanged. The exception is a wire whose open_mask bit (bit c*CHAIN_LEN+w for chain c, wire w) is 1: it captures 0.
- R4: In scan mode, on shift cycle k (k = 0 first) of a vector, scan_out[c] presents the capture of wire CHAIN_LEN-1-k of chain c.
- R5: In scan mode, the first shift cycle that shows a mismatch ends the run. The block reports fault_wire = CHAIN_LEN-1-k, fault_chain = the lowest-numbered chain that mismatches in that cycle, and fault_vec = the vector index.
- R6: In readback mode, all captures of a vector are compared in one cycle. Among the mismatching wires, the block reports the highest wire index, and the lowest chain among those. This is the same location scan mode would report.
- R7: Counted in clock edges after the edge that samples start, done rises at these edges. In scan mode: 4*(CHAIN_LEN+1) for a pass, and 2+v*(CHAIN_LEN+1)+k for a fault at vector v, shift k. In readback mode: 8 for a pass, and 2+2v for a fault at vector v.
- R8: When every vector passes on every chain, the run ends with done = 1 and fault_found = 0.
- R9: Once done is 1, it stays 1 and the result outputs stay unchanged until the next start. Start pulses during a busy run have no effect.
- R10: Because an open forces 0, vector 0 never detects a fault. An open on an odd wire is first caught by vector 1, and an open on an even wire by vector 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begins a run when idle or done |
| readback_mode | input | 1 | 1: parallel readback, 0: serial scan (latched at start) |
| open_mask | input | NUM_CHAINS*CHAIN_LEN | Per-wire open fault injection, bit c*CHAIN_LEN+w |
| busy | output | 1 | A run is in progress |
| done | output | 1 | Run finished, results valid |
| fault_found | output | 1 | A mismatch was located |
| fault_chain | output | CHAIN_W | Chain of the located fault |
| fault_wire | output | WIRE_W | Wire index of the located fault |
| fault_vec | output | 2 | Vector index that exposed the fault |
| scan_out | output | NUM_CHAINS | Serial primary output of each chain |

## Verification
The bench goes after the wires at both ends of a chain. If the shift-count mapping were reversed or off by one, it would report the mirror wire or a neighbour. It injects opens on odd and even wires together. A design that applied the vectors in a different order, or missed the polarity rule, would blame the wrong wire or vector. Twin faults at the same wire index on different chains would expose a wrong chain priority. Readback runs are compared against the scan verdict and timing. Each run also counts its latency in edges and watches every scan_out bit. A design that skipped the capture delay, or honoured a start pulse mid-run, would show up as a shifted done edge or a changed result.

// File: rtl/wut_pkg.sv
// Shared types and the test vector rule for the wire-under-test localizer.
// Assumes exactly four vectors, indexed by a 2-bit value.
package wut_pkg;

    localparam int NUM_VEC = 4;
    localparam int VEC_W   = 2;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_CAPT  = 3'd1,
        ST_SHIFT = 3'd2,
        ST_RB    = 3'd3,
        ST_DONE  = 3'd4
    } state_t;

    // Value driven onto wire w by vector v: zeros, odd-high, even-high, ones.
    function automatic logic vec_bit(input logic [VEC_W-1:0] v, input logic [31:0] w);
        case (v)
            2'd0:    vec_bit = 1'b0;
            2'd1:    vec_bit = w[0];
            2'd2:    vec_bit = ~w[0];
            default: vec_bit = 1'b1;
        endcase
    endfunction

endpackage

// File: rtl/wut_vector_gen.sv
// Expands a vector index into the full source pattern for every wire of
// every chain. Purely combinational; all chains receive the same pattern.
module wut_vector_gen #(
    parameter int NUM_CHAINS = 4,
    parameter int CHAIN_LEN  = 8
) (
    input  logic [wut_pkg::VEC_W-1:0]        vec_idx,
    output logic [NUM_CHAINS*CHAIN_LEN-1:0]  pattern
);
    import wut_pkg::*;

    // Fill each wire position from the vector rule.
    always_comb begin
        pattern = '0;
        for (int c = 0; c < NUM_CHAINS; c++) begin
            for (int w = 0; w < CHAIN_LEN; w++) begin
                pattern[c*CHAIN_LEN + w] = vec_bit(vec_idx, 32'(w));
            end
        end
    end

endmodule

// File: rtl/wut_capture_chains.sv
// Source launch registers, wires with open-fault injection, and the capture
// flip-flops that double as serial shift chains. Wire w of chain c sits at
// bit w of its chain; bit CHAIN_LEN-1 drives the chain's primary output.
// Assumes CHAIN_LEN >= 2 and that open_mask is steady during a run.
module wut_capture_chains #(
    parameter int NUM_CHAINS = 4,
    parameter int CHAIN_LEN  = 8
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            launch_en,
    input  logic [NUM_CHAINS*CHAIN_LEN-1:0] launch_pat,
    input  logic                            capt_en,
    input  logic                            shift_en,
    input  logic [NUM_CHAINS*CHAIN_LEN-1:0] open_mask,
    output logic [NUM_CHAINS*CHAIN_LEN-1:0] cap_flat,
    output logic [NUM_CHAINS-1:0]           scan_out
);
    localparam int TOTAL = NUM_CHAINS * CHAIN_LEN;

    logic [TOTAL-1:0]     src_q;
    logic [CHAIN_LEN-1:0] cap_q [NUM_CHAINS];

    // Launch sources, capture through identity logic, or shift toward output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q <= '0;
            for (int c = 0; c < NUM_CHAINS; c++) cap_q[c] <= '0;
        end else begin
            if (launch_en) src_q <= launch_pat;
            if (capt_en) begin
                for (int c = 0; c < NUM_CHAINS; c++)
                    cap_q[c] <= src_q[c*CHAIN_LEN +: CHAIN_LEN] & ~open_mask[c*CHAIN_LEN +: CHAIN_LEN];
            end else if (shift_en) begin
                for (int c = 0; c < NUM_CHAINS; c++)
                    cap_q[c] <= {cap_q[c][CHAIN_LEN-2:0], 1'b0};
            end
        end
    end

    for (genvar c = 0; c < NUM_CHAINS; c++) begin : g_chain
        assign cap_flat[c*CHAIN_LEN +: CHAIN_LEN] = cap_q[c];
        assign scan_out[c] = cap_q[c][CHAIN_LEN-1];

        // R3: an open wire never leaves a 1 in its capture flip-flop.
        a_r3_open_zero: assert property (@(posedge clk) disable iff (!rst_n)
            capt_en |=> ((cap_q[c] & $past(open_mask[c*CHAIN_LEN +: CHAIN_LEN])) == '0));

        // R4: each shift moves the next-nearer wire onto the primary output.
        a_r4_shift_step: assert property (@(posedge clk) disable iff (!rst_n)
            (shift_en && !capt_en) |=> (scan_out[c] == $past(cap_q[c][CHAIN_LEN-2])));
    end

endmodule

// File: rtl/wut_mismatch_locator.sv
// Compares captured values with the expected pattern and picks the reported
// location. Scan mode looks only at the bit at each chain's output; readback
// mode looks at every capture and picks the highest wire, then lowest chain.
module wut_mismatch_locator #(
    parameter int NUM_CHAINS = 4,
    parameter int CHAIN_LEN  = 8,
    parameter int CHAIN_W    = 2,
    parameter int WIRE_W     = 3
) (
    input  logic                            readback,
    input  logic [WIRE_W-1:0]               shift_cnt,
    input  logic [NUM_CHAINS*CHAIN_LEN-1:0] cap_flat,
    input  logic [NUM_CHAINS*CHAIN_LEN-1:0] exp_flat,
    output logic                            hit,
    output logic [CHAIN_W-1:0]              hit_chain,
    output logic [WIRE_W-1:0]               hit_wire
);
    int wsel;

    // Select the mismatch to report; later loop writes take priority.
    always_comb begin
        hit       = 1'b0;
        hit_chain = '0;
        hit_wire  = '0;
        wsel      = 0;
        if (readback) begin
            for (int w = 0; w < CHAIN_LEN; w++) begin
                for (int c = NUM_CHAINS-1; c >= 0; c--) begin
                    if (cap_flat[c*CHAIN_LEN + w] != exp_flat[c*CHAIN_LEN + w]) begin
                        hit       = 1'b1;
                        hit_chain = CHAIN_W'(c);
                        hit_wire  = WIRE_W'(w);
                    end
                end
            end
        end else begin
            wsel = CHAIN_LEN - 1 - int'(shift_cnt);
            for (int c = NUM_CHAINS-1; c >= 0; c--) begin
                if (cap_flat[c*CHAIN_LEN + CHAIN_LEN - 1] != exp_flat[c*CHAIN_LEN + wsel]) begin
                    hit       = 1'b1;
                    hit_chain = CHAIN_W'(c);
                    hit_wire  = WIRE_W'(wsel);
                end
            end
        end
    end

endmodule

// File: rtl/wut_scan_localizer.sv
// Top of the wire-under-test localizer: sequences the four test vectors,
// launches and captures them, then scans or reads back the captures and
// reports the first faulty wire. Stops at the first fault found.
// Assumes open_mask and readback_mode are steady while busy.
module wut_scan_localizer #(
    parameter int NUM_CHAINS = 4,
    parameter int CHAIN_LEN  = 8,
    localparam int CHAIN_W   = (NUM_CHAINS > 1) ? $clog2(NUM_CHAINS) : 1,
    localparam int WIRE_W    = (CHAIN_LEN > 1) ? $clog2(CHAIN_LEN) : 1
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            start,
    input  logic                            readback_mode,
    input  logic [NUM_CHAINS*CHAIN_LEN-1:0] open_mask,
    output logic                            busy,
    output logic                            done,
    output logic                            fault_found,
    output logic [CHAIN_W-1:0]              fault_chain,
    output logic [WIRE_W-1:0]               fault_wire,
    output logic [1:0]                      fault_vec,
    output logic [NUM_CHAINS-1:0]           scan_out
);
    import wut_pkg::*;

    localparam int TOTAL = NUM_CHAINS * CHAIN_LEN;
    localparam logic [VEC_W-1:0]  LAST_VEC  = VEC_W'(NUM_VEC - 1);
    localparam logic [WIRE_W-1:0] LAST_SHIFT = WIRE_W'(CHAIN_LEN - 1);

    state_t              state_q;
    logic [VEC_W-1:0]    vec_q;
    logic [VEC_W-1:0]    launch_vec;
    logic [WIRE_W-1:0]   cnt_q;
    logic                rb_q;
    logic                launch_en;
    logic                accept;
    logic                hit;
    logic [CHAIN_W-1:0]  hit_chain;
    logic [WIRE_W-1:0]   hit_wire;
    logic [TOTAL-1:0]    exp_pat;
    logic [TOTAL-1:0]    launch_pat;
    logic [TOTAL-1:0]    cap_flat;

    // Decide when a new vector is launched and which one.
    always_comb begin
        accept     = (state_q == ST_IDLE || state_q == ST_DONE) && start;
        launch_vec = accept ? '0 : vec_q + 1'b1;
        launch_en  = accept
                   || (state_q == ST_SHIFT && !hit && cnt_q == LAST_SHIFT && vec_q != LAST_VEC)
                   || (state_q == ST_RB && !hit && vec_q != LAST_VEC);
    end

    wut_vector_gen #(.NUM_CHAINS(NUM_CHAINS), .CHAIN_LEN(CHAIN_LEN)) u_exp_gen (
        .vec_idx (vec_q),
        .pattern (exp_pat)
    );

    wut_vector_gen #(.NUM_CHAINS(NUM_CHAINS), .CHAIN_LEN(CHAIN_LEN)) u_launch_gen (
        .vec_idx (launch_vec),
        .pattern (launch_pat)
    );

    wut_capture_chains #(.NUM_CHAINS(NUM_CHAINS), .CHAIN_LEN(CHAIN_LEN)) u_chains (
        .clk        (clk),
        .rst_n      (rst_n),
        .launch_en  (launch_en),
        .launch_pat (launch_pat),
        .capt_en    (state_q == ST_CAPT),
        .shift_en   (state_q == ST_SHIFT),
        .open_mask  (open_mask),
        .cap_flat   (cap_flat),
        .scan_out   (scan_out)
    );

    wut_mismatch_locator #(
        .NUM_CHAINS (NUM_CHAINS),
        .CHAIN_LEN  (CHAIN_LEN),
        .CHAIN_W    (CHAIN_W),
        .WIRE_W     (WIRE_W)
    ) u_locator (
        .readback  (rb_q),
        .shift_cnt (cnt_q),
        .cap_flat  (cap_flat),
        .exp_flat  (exp_pat),
        .hit       (hit),
        .hit_chain (hit_chain),
        .hit_wire  (hit_wire)
    );

    // Run sequencer: vector, capture, observe, then next vector or finish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            vec_q       <= '0;
            cnt_q       <= '0;
            rb_q        <= 1'b0;
            fault_found <= 1'b0;
            fault_chain <= '0;
            fault_wire  <= '0;
            fault_vec   <= '0;
        end else begin
            case (state_q)
                ST_IDLE, ST_DONE: begin
                    if (start) begin
                        state_q     <= ST_CAPT;
                        vec_q       <= '0;
                        rb_q        <= readback_mode;
                        fault_found <= 1'b0;
                        fault_chain <= '0;
                        fault_wire  <= '0;
                        fault_vec   <= '0;
                    end
                end
                ST_CAPT: begin
                    state_q <= rb_q ? ST_RB : ST_SHIFT;
                    cnt_q   <= '0;
                end
                ST_SHIFT, ST_RB: begin
                    if (hit) begin
                        state_q     <= ST_DONE;
                        fault_found <= 1'b1;
                        fault_chain <= hit_chain;
                        fault_wire  <= hit_wire;
                        fault_vec   <= vec_q;
                    end else if (state_q == ST_SHIFT && cnt_q != LAST_SHIFT) begin
                        cnt_q <= cnt_q + 1'b1;
                    end else if (vec_q == LAST_VEC) begin
                        state_q <= ST_DONE;
                    end else begin
                        vec_q   <= vec_q + 1'b1;
                        state_q <= ST_CAPT;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign busy = (state_q == ST_CAPT) || (state_q == ST_SHIFT) || (state_q == ST_RB);
    assign done = (state_q == ST_DONE);

    // R5: a reported fault always comes with done and a wire inside the chain.
    a_r5_fault_valid: assert property (@(posedge clk) disable iff (!rst_n)
        fault_found |-> (done && (int'(fault_wire) < CHAIN_LEN)));

    // R8: a clean finish only after the last vector has been observed.
    a_r8_pass_last_vec: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !fault_found) |-> (vec_q == LAST_VEC));

    // R9: results hold while done and no new start arrives.
    a_r9_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> (done && $stable(fault_found) && $stable(fault_chain)
                              && $stable(fault_wire) && $stable(fault_vec)));

    // R9: a run only begins from a start pulse.
    a_r9_busy_from_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

    // R10: vector 0 can never expose an open, since it drives only zeros.
    a_r10_no_vec0_fault: assert property (@(posedge clk) disable iff (!rst_n)
        fault_found |-> (fault_vec != 2'd0));

endmodule

// File: tb/wut_scan_localizer_tb.sv
// Self-checking bench: directed corner cases plus seeded random fault masks.
module wut_scan_localizer_tb;
    localparam int NC = 4;
    localparam int CL = 8;
    localparam int CW = 2;
    localparam int WW = 3;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic             readback_mode = 1'b0;
    logic [NC*CL-1:0] open_mask = '0;
    logic             busy, done, fault_found;
    logic [CW-1:0]    fault_chain;
    logic [WW-1:0]    fault_wire;
    logic [1:0]       fault_vec;
    logic [NC-1:0]    scan_out;

    int total = 0;
    int bad = 0;

    always #4 clk = ~clk;

    wut_scan_localizer #(.NUM_CHAINS(NC), .CHAIN_LEN(CL)) u_dut (
        .clk (clk), .rst_n (rst_n), .start (start), .readback_mode (readback_mode),
        .open_mask (open_mask), .busy (busy), .done (done), .fault_found (fault_found),
        .fault_chain (fault_chain), .fault_wire (fault_wire), .fault_vec (fault_vec),
        .scan_out (scan_out)
    );

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int pat(input int v, input int w);
        case (v)
            0: return 0;
            1: return w % 2;
            2: return 1 - (w % 2);
            default: return 1;
        endcase
    endfunction

    // First fault as scan order sees it: vector, then shift, then lowest chain.
    function automatic bit model(input logic [NC*CL-1:0] m, output int fc, output int fw,
                                 output int fv, output int fk);
        fc = 0; fw = 0; fv = 0; fk = 0;
        for (int v = 0; v < 4; v++)
            for (int k = 0; k < CL; k++)
                for (int c = 0; c < NC; c++)
                    if (m[c*CL + CL-1-k] && pat(v, CL-1-k) == 1) begin
                        fc = c; fw = CL-1-k; fv = v; fk = k;
                        return 1'b1;
                    end
        return 1'b0;
    endfunction

    task automatic run(input bit rb, input logic [NC*CL-1:0] m, input bit mid_start, input string tag);
        int n, fc, fw, fv, fk, exp_lat, scan_err;
        bit ef;
        logic [CW-1:0] hc;
        logic [WW-1:0] hw;
        ef = model(m, fc, fw, fv, fk);
        if (rb) exp_lat = ef ? 2 + 2*fv : 8;
        else    exp_lat = ef ? 2 + fv*(CL+1) + fk : 4*(CL+1);
        @(negedge clk);
        open_mask = m; readback_mode = rb; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        n = 0; scan_err = 0;
        while (!done && n < 200) begin
            @(negedge clk);
            n++;
            if (mid_start && n == 3) start = 1'b1;
            if (mid_start && n == 4) start = 1'b0;
            if (!rb && !done && ((n-1) % (CL+1)) < CL) begin
                for (int c = 0; c < NC; c++) begin
                    int w, v, e;
                    v = (n-1) / (CL+1);
                    w = CL-1-((n-1) % (CL+1));
                    e = m[c*CL+w] ? 0 : pat(v, w);
                    if (int'(scan_out[c]) != e) scan_err++;
                end
            end
        end
        chk(n == exp_lat, "R7", {tag, " done latency"}, n, exp_lat);
        chk(fault_found == ef, ef ? "R5 R6" : "R8", {tag, " fault_found"}, int'(fault_found), int'(ef));
        if (ef) begin
            chk(int'(fault_chain) == fc, rb ? "R6" : "R5", {tag, " chain"}, int'(fault_chain), fc);
            chk(int'(fault_wire) == fw, rb ? "R6" : "R5", {tag, " wire"}, int'(fault_wire), fw);
            chk(int'(fault_vec) == fv, "R10", {tag, " vector"}, int'(fault_vec), fv);
        end
        if (!rb) chk(scan_err == 0, "R2 R4", {tag, " scan_out stream errors"}, scan_err, 0);
        hc = fault_chain; hw = fault_wire;
        repeat (3) @(negedge clk);
        chk(done && fault_chain == hc && fault_wire == hw, "R9", {tag, " result hold"},
            int'(done), 1);
    endtask

    initial begin
        logic [NC*CL-1:0] m;
        void'($urandom(32'd20240611));
        repeat (2) @(negedge clk);
        chk(!busy && !done && !fault_found && scan_out == '0 && fault_wire == '0
            && fault_chain == '0 && fault_vec == '0, "R1", "state in reset", int'(done), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done && !fault_found, "R1", "state after reset", int'(busy), 0);

        run(1'b0, '0, 1'b0, "R8 scan clean");
        run(1'b1, '0, 1'b0, "R8 readback clean");
        run(1'b0, '0, 1'b1, "R9 scan clean start-mid-run");
        m = '0; m[0*CL + CL-1] = 1'b1;
        run(1'b0, m, 1'b0, "R5 first-out wire");
        run(1'b1, m, 1'b0, "R6 first-out wire");
        m = '0; m[(NC-1)*CL + 0] = 1'b1;
        run(1'b0, m, 1'b0, "R5 last-out wire");
        run(1'b1, m, 1'b0, "R6 last-out wire");
        m = '0; m[1*CL + 5] = 1'b1; m[3*CL + 5] = 1'b1;
        run(1'b0, m, 1'b0, "R5 twin chains");
        run(1'b1, m, 1'b0, "R6 twin chains");
        m = '0; m[0*CL + 1] = 1'b1; m[3*CL + 6] = 1'b1;
        run(1'b0, m, 1'b0, "R10 odd before even");
        run(1'b1, m, 1'b1, "R10 readback odd before even");
        m = '0; m[2*CL + 3] = 1'b1;
        run(1'b0, m, 1'b1, "R3 R9 fault start-mid-run");

        for (int i = 0; i < 24; i++) begin
            int nb;
            m = '0;
            nb = $urandom_range(0, 3);
            for (int j = 0; j < nb; j++)
                m[$urandom_range(0, NC-1)*CL + $urandom_range(0, CL-1)] = 1'b1;
            run(i[0], m, 1'b0, "R3 random");
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(200000 * 8);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule